// File: doc/BRIEF.md
# Conversion Result Port Controller

This block is the digital face of a 12-bit sampling converter. A host lowers a read/convert strobe while chip select is low. If the strobe stays low for an accepted number of clock cycles, the block starts an internal conversion timer when the strobe goes high again, and it drops busy for a fixed number of cycles. When the timer expires, the block latches the value on a stimulus input into its result register and raises busy again. That stimulus input stands in for the converter core, and the value it latches is a two's-complement code.

The result is read over two 8-bit lanes. The lanes are enabled only while the strobe is high and chip select is low. The byte-select input decides which half of the 12-bit word appears on which lane, and the unused lane bits read as zero. After a new conversion starts, the previous result stays readable for a limited number of cycles. From then until busy rises, both lanes carry a fixed poison pattern.

The FSM has four states. IDLE waits for a qualified falling edge. ARMED measures the width of the low pulse. CONV runs the conversion timer. REJECT waits out an over-long pulse. The transitions are named as follows:

- IDLE to ARMED: the strobe falls while chip select is low.
- ARMED to CONV: the strobe rises with a width in range.
- ARMED to IDLE: the strobe rises too early.
- ARMED to REJECT: the width limit is reached while the strobe is still low.
- REJECT to IDLE: the strobe rises.
- CONV to IDLE: the timer expires, and the result is latched at the same time.

Top module: `cvt_port_ctrl`

## Requirements
- R1: After reset, busy is high and the result register holds 0x000, so enabled lanes read 0x00 on both lanes.
- R2: A qualified request is a strobe low for N sampled cycles, with MIN_PULSE <= N <= MAX_PULSE, after a falling edge seen with chip select low. Busy goes low in the first cycle after the strobe is sampled high again, and it stays low for exactly CONV_CYC cycles.
- R3: A low pulse shorter than MIN_PULSE cycles or longer than MAX_PULSE cycles starts no conversion: busy stays high and the stored result is unchanged.
- R4: A strobe falling edge while chip select is high starts no conversion.
- R5: A strobe pulse arriving while busy is low is ignored. The running conversion finishes on time and no second conversion follows.
- R6: The result register takes the value of the sample input present at the clock edge where busy returns high, and not the value present when the conversion started.
- R7: Both lane enables are high only while the strobe is high and chip select is low. Whenever the lanes are disabled, both lane data outputs are 0x00.
- R8: With byte select low, lane A carries result bits 11 down to 4. Lane B carries bits 3 down to 0 in its bit positions 3 down to 0, and its bits 7 down to 4 are 0.
- R9: With byte select high, lane A carries result bits 3 down to 0 in its bit positions 3 down to 0, and its bits 7 down to 4 are 0. Lane B carries result bits 11 down to 4.
- R10: During a conversion, enabled lanes show the previous result for the first STALE_CYC cycles of busy low. For the remaining cycles until busy rises, both lanes show POISON (0xA5 by default).
- R11: Codes are passed unaltered as 12-bit two's complement: 0x7FF, 0x000, 0xFFF and 0x800 each read back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rc_i | input | 1 | Read/convert strobe: low pulse requests a conversion, high allows reading |
| cs_n_i | input | 1 | Active-low chip select |
| byte_sel_i | input | 1 | Selects which half of the result appears on which lane |
| sample_i | input | DATA_W | Two's-complement sample from the converter core |
| busy_o | output | 1 | Low while a conversion runs, high when the result is valid |
| lane_a_o | output | LANE_W | Lane A data |
| lane_a_oe_o | output | 1 | Lane A driver enable (low means high impedance) |
| lane_b_o | output | LANE_W | Lane B data |
| lane_b_oe_o | output | 1 | Lane B driver enable (low means high impedance) |

## Verification
The hardest situation to reach is a second request issued in the middle of a conversion. The bench must issue a full, correctly sized strobe pulse inside the busy-low window and then prove that nothing followed it. The driver times this pulse to start a few cycles after busy falls and to end well before the timer expires. The scoreboard then flags any busy rise that has no queued expectation. A similar issue arises at the stale-window edge, which only exists inside a conversion. The bench reaches it by counting falling clock edges from the start of conversion and reading the lanes in the last stale cycle and in the first poisoned cycle.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_CONV   = 2'd2,
        ST_REJECT = 2'd3
    } cvt_state_e;

endpackage

// File: rtl/cvt_seq.sv
module cvt_seq
    import cvt_pkg::*;
#(
    parameter int MIN_PULSE = 5,
    parameter int MAX_PULSE = 750,
    parameter int CONV_CYC  = 1000,
    parameter int STALE_CYC = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rc_i,
    input  logic cs_n_i,
    output logic busy_o,
    output logic capture_o,
    output logic stale_o
);

    localparam int WW = $clog2(MAX_PULSE + 1);
    localparam int CW = $clog2(CONV_CYC + 1);

    cvt_state_e      state, state_nx;
    logic            rc_q;
    logic            req_fall;
    logic [WW-1:0]   wcnt;
    logic [CW-1:0]   ccnt;
    logic            timer_done;

    assign req_fall   = rc_q & ~rc_i & ~cs_n_i;
    assign timer_done = (ccnt == CW'(CONV_CYC - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_fall) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (rc_i) begin
                    state_nx = (wcnt >= WW'(MIN_PULSE)) ? ST_CONV : ST_IDLE;
                end else if (wcnt >= WW'(MAX_PULSE)) begin
                    state_nx = ST_REJECT;
                end
            end
            ST_CONV: begin
                if (timer_done) state_nx = ST_IDLE;
            end
            ST_REJECT: begin
                if (rc_i) state_nx = ST_IDLE;
            end
        endcase
    end

    // Strobe history, pulse width and conversion timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_q <= 1'b1;
            wcnt <= '0;
            ccnt <= '0;
        end else begin
            rc_q <= rc_i;
            if (state == ST_IDLE && req_fall) begin
                wcnt <= WW'(1);
            end else if (state == ST_ARMED && !rc_i && wcnt < WW'(MAX_PULSE)) begin
                wcnt <= wcnt + WW'(1);
            end
            ccnt <= (state == ST_CONV) ? ccnt + CW'(1) : '0;
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy_o    = 1'b1;
        capture_o = 1'b0;
        stale_o   = 1'b0;
        unique case (state)
            ST_CONV: begin
                busy_o    = 1'b0;
                capture_o = timer_done;
                stale_o   = (ccnt >= CW'(STALE_CYC));
            end
            ST_IDLE, ST_ARMED, ST_REJECT: begin
                busy_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cvt_result_reg.sv
module cvt_result_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic [DATA_W-1:0] result_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         result_o <= '0;
        else if (capture_i) result_o <= sample_i;
    end

endmodule

// File: rtl/cvt_lane_mux.sv
module cvt_lane_mux #(
    parameter int               DATA_W = 12,
    parameter int               LANE_W = 8,
    parameter logic [LANE_W-1:0] POISON = 8'hA5
) (
    input  logic              rc_i,
    input  logic              cs_n_i,
    input  logic              byte_sel_i,
    input  logic              stale_i,
    input  logic [DATA_W-1:0] result_i,
    output logic [LANE_W-1:0] lane_a_o,
    output logic [LANE_W-1:0] lane_b_o,
    output logic              lane_oe_o
);

    localparam int LO_W  = DATA_W - LANE_W;
    localparam int PAD_W = LANE_W - LO_W;

    logic [LANE_W-1:0] hi_part, lo_part;

    always_comb begin
        lane_oe_o = rc_i & ~cs_n_i;
        if (stale_i) begin
            hi_part = POISON;
            lo_part = POISON;
        end else begin
            hi_part = result_i[DATA_W-1:LO_W];
            lo_part = {{PAD_W{1'b0}}, result_i[LO_W-1:0]};
        end
        if (!lane_oe_o) begin
            lane_a_o = '0;
            lane_b_o = '0;
        end else if (byte_sel_i) begin
            lane_a_o = lo_part;
            lane_b_o = hi_part;
        end else begin
            lane_a_o = hi_part;
            lane_b_o = lo_part;
        end
    end

endmodule

// File: rtl/cvt_port_ctrl.sv
module cvt_port_ctrl #(
    parameter int                DATA_W    = 12,
    parameter int                LANE_W    = 8,
    parameter int                MIN_PULSE = 5,
    parameter int                MAX_PULSE = 750,
    parameter int                CONV_CYC  = 1000,
    parameter int                STALE_CYC = 600,
    parameter logic [LANE_W-1:0] POISON    = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rc_i,
    input  logic              cs_n_i,
    input  logic              byte_sel_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              busy_o,
    output logic [LANE_W-1:0] lane_a_o,
    output logic              lane_a_oe_o,
    output logic [LANE_W-1:0] lane_b_o,
    output logic              lane_b_oe_o
);

    logic              capture;
    logic              stale;
    logic              lane_oe;
    logic [DATA_W-1:0] result_q;

    cvt_seq #(
        .MIN_PULSE (MIN_PULSE),
        .MAX_PULSE (MAX_PULSE),
        .CONV_CYC  (CONV_CYC),
        .STALE_CYC (STALE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rc_i      (rc_i),
        .cs_n_i    (cs_n_i),
        .busy_o    (busy_o),
        .capture_o (capture),
        .stale_o   (stale)
    );

    cvt_result_reg #(
        .DATA_W (DATA_W)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .sample_i  (sample_i),
        .result_o  (result_q)
    );

    cvt_lane_mux #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W),
        .POISON (POISON)
    ) u_lanes (
        .rc_i       (rc_i),
        .cs_n_i     (cs_n_i),
        .byte_sel_i (byte_sel_i),
        .stale_i    (stale),
        .result_i   (result_q),
        .lane_a_o   (lane_a_o),
        .lane_b_o   (lane_b_o),
        .lane_oe_o  (lane_oe)
    );

    assign lane_a_oe_o = lane_oe;
    assign lane_b_oe_o = lane_oe;

endmodule

// File: rtl/cvt_port_ctrl_chk.sv
module cvt_port_ctrl_chk #(
    parameter int DATA_W   = 12,
    parameter int LANE_W   = 8,
    parameter int CONV_CYC = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rc_i,
    input logic              byte_sel_i,
    input logic              busy_o,
    input logic [LANE_W-1:0] lane_a_o,
    input logic              lane_a_oe_o,
    input logic [LANE_W-1:0] lane_b_o,
    input logic              lane_b_oe_o,
    input logic [DATA_W-1:0] result_q
);

    localparam int LO_W = DATA_W - LANE_W;
    localparam int CW   = $clog2(CONV_CYC + 2);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      low_cnt <= '0;
        else if (!busy_o) low_cnt <= low_cnt + CW'(1);
        else             low_cnt <= '0;
    end

    // R2: busy low lasts exactly CONV_CYC cycles
    a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (low_cnt == CW'(CONV_CYC)));

    // R2: a conversion starts only once the strobe has returned high
    a_r2_start_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(rc_i));

    // R6: the result only changes as busy returns high
    a_r6_capture_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_q) |-> $rose(busy_o));

    // R7: disabled lanes read zero
    a_r7_off_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(lane_a_oe_o || lane_b_oe_o) |-> (lane_a_o == '0 && lane_b_o == '0));

    // R8: padding bits of lane B are low when byte select is low
    a_r8_lane_b_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_b_oe_o && !byte_sel_i && busy_o) |-> (lane_b_o[LANE_W-1:LO_W] == '0));

    // R9: padding bits of lane A are low when byte select is high
    a_r9_lane_a_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_a_oe_o && byte_sel_i && busy_o) |-> (lane_a_o[LANE_W-1:LO_W] == '0));

endmodule

bind cvt_port_ctrl cvt_port_ctrl_chk #(
    .DATA_W   (DATA_W),
    .LANE_W   (LANE_W),
    .CONV_CYC (CONV_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rc_i        (rc_i),
    .byte_sel_i  (byte_sel_i),
    .busy_o      (busy_o),
    .lane_a_o    (lane_a_o),
    .lane_a_oe_o (lane_a_oe_o),
    .lane_b_o    (lane_b_o),
    .lane_b_oe_o (lane_b_oe_o),
    .result_q    (result_q)
);

// File: tb/cvt_port_ctrl_tb.sv
`timescale 1ns/1ps
module cvt_port_ctrl_tb;

    localparam int MIN_P = 3;
    localparam int MAX_P = 12;
    localparam int CONV  = 30;
    localparam int STALE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rc = 1'b1;
    logic        cs_n = 1'b0;
    logic        bsel = 1'b0;
    logic [11:0] sample = 12'h000;
    logic        busy;
    logic [7:0]  lane_a, lane_b;
    logic        oe_a, oe_b;

    int checks = 0;
    int errors = 0;
    int rises  = 0;
    int low_len = 0;
    bit busy_prev = 1'b1;
    bit done = 1'b0;
    logic [11:0] exp_q[$];

    always #4 clk = ~clk;

    cvt_port_ctrl #(
        .MIN_PULSE (MIN_P),
        .MAX_PULSE (MAX_P),
        .CONV_CYC  (CONV),
        .STALE_CYC (STALE)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rc_i        (rc),
        .cs_n_i      (cs_n),
        .byte_sel_i  (bsel),
        .sample_i    (sample),
        .busy_o      (busy),
        .lane_a_o    (lane_a),
        .lane_a_oe_o (oe_a),
        .lane_b_o    (lane_b),
        .lane_b_oe_o (oe_b)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reads the 12-bit result through the lanes with byte select low
    function automatic logic [11:0] read_lo();
        return {lane_a, lane_b[3:0]};
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy) low_len++;
            if (busy && !busy_prev) begin
                rises++;
                chk(low_len == CONV, "R2 busy low length", 16'(low_len), 16'(CONV));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R5 unexpected conversion", {4'h0, read_lo()}, 16'hFFFF);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    chk(read_lo() == e && oe_a && oe_b && lane_b[7:4] == 4'h0,
                        "R6/R8/R11 result readback", {4'h0, read_lo()}, {4'h0, e});
                end
            end
            if (busy) low_len = 0;
            busy_prev = busy;
        end
    end

    task automatic pulse(input int n);
        @(negedge clk);
        rc = 1'b0;
        repeat (n) @(negedge clk);
        rc = 1'b1;
    endtask

    task automatic convert(input logic [11:0] v, input int n);
        sample = v;
        exp_q.push_back(v);
        pulse(n);
        repeat (CONV + 3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b1, "R1 busy after reset", 16'(busy), 16'h1);
        chk(lane_a == 8'h00 && lane_b == 8'h00 && oe_a, "R1 lanes after reset",
            {lane_a, lane_b}, 16'h0000);

        // R7: enable decode
        cs_n = 1'b1;
        @(negedge clk);
        chk(!oe_a && !oe_b && lane_a == 0 && lane_b == 0, "R7 cs high disables",
            {7'h0, oe_a, lane_a}, 16'h0000);

        // R4: strobe pulse with chip select high
        r0 = rises;
        pulse(MIN_P);
        chk(!oe_a && !oe_b, "R7 rc low with cs high disables", {15'h0, oe_a}, 16'h0);
        repeat (CONV + 5) @(negedge clk);
        chk(rises == r0 && busy, "R4 no conversion with cs high", 16'(rises), 16'(r0));
        cs_n = 1'b0;
        @(negedge clk);

        // R7: rc low with cs low disables lanes (seen inside pulse)
        fork
            pulse(MIN_P);
            begin
                @(negedge clk); @(negedge clk);
                chk(!oe_a && !oe_b && lane_a == 0, "R7 rc low disables", {7'h0, oe_a, lane_a}, 16'h0);
            end
        join
        exp_q.push_back(12'h000);
        repeat (CONV + 3) @(negedge clk);

        // R11 / R2: full-scale codes, min and max widths
        convert(12'h7FF, MIN_P);
        // R8: byte low mapping
        chk(lane_a == 8'h7F && lane_b == 8'h0F, "R8 byte low lanes", {lane_a, lane_b}, 16'h7F0F);
        bsel = 1'b1;
        @(negedge clk);
        // R9: byte high mapping
        chk(lane_a == 8'h0F && lane_b == 8'h7F, "R9 byte high lanes", {lane_a, lane_b}, 16'h0F7F);
        bsel = 1'b0;
        convert(12'h800, MAX_P);
        convert(12'hFFF, MAX_P);
        convert(12'h000, MIN_P + 1);
        convert(12'h5A3, MIN_P);
        bsel = 1'b1;
        @(negedge clk);
        chk(lane_a == 8'h03 && lane_b == 8'h5A, "R9 byte high mixed code", {lane_a, lane_b}, 16'h035A);
        bsel = 1'b0;
        @(negedge clk);

        // R3: too short and too long pulses
        r0 = rises;
        pulse(MIN_P - 1);
        repeat (CONV + 5) @(negedge clk);
        chk(rises == r0 && busy && read_lo() == 12'h5A3, "R3 short pulse ignored",
            {4'h0, read_lo()}, 16'h05A3);
        pulse(MAX_P + 1);
        repeat (CONV + 5) @(negedge clk);
        chk(rises == r0 && busy && read_lo() == 12'h5A3, "R3 long pulse ignored",
            {4'h0, read_lo()}, 16'h05A3);

        // R5: request during busy low
        r0 = rises;
        sample = 12'h123;
        exp_q.push_back(12'h123);
        pulse(MIN_P);
        repeat (3) @(negedge clk);
        chk(!busy, "R2 busy low during conversion", 16'(busy), 16'h0);
        pulse(MIN_P);
        repeat (2 * CONV + 5) @(negedge clk);
        chk(rises == r0 + 1 && busy, "R5 request during busy ignored", 16'(rises), 16'(r0 + 1));

        // R10: stale window then poison
        sample = 12'h9C4;
        exp_q.push_back(12'h9C4);
        pulse(MIN_P);
        repeat (STALE) @(negedge clk);
        chk(read_lo() == 12'h123 && !busy, "R10 previous data in window",
            {4'h0, read_lo()}, 16'h0123);
        @(negedge clk);
        chk(lane_a == 8'hA5 && lane_b == 8'hA5 && !busy, "R10 poison after window",
            {lane_a, lane_b}, 16'hA5A5);
        repeat (CONV) @(negedge clk);

        // R6: sample changes mid-conversion, end value is taken
        sample = 12'h111;
        exp_q.push_back(12'h6E2);
        pulse(MIN_P);
        repeat (5) @(negedge clk);
        sample = 12'h6E2;
        repeat (CONV + 3) @(negedge clk);
        chk(read_lo() == 12'h6E2, "R6 end-of-conversion sample", {4'h0, read_lo()}, 16'h06E2);

        chk(exp_q.size() == 0, "R2 all expected conversions seen", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule